// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block provides three independent 16-bit down-counters behind a small 8-bit port interface. Software reaches it through four addresses: one data port for each counter and one shared port for command bytes. A command byte either programs a counter (how its reload value is written and read, its counting mode, and binary or BCD arithmetic), freezes a copy of a counter's value for later reading, or, through the multi-channel read-back form, freezes counts and arms status bytes on any set of counters at once.

All three counters step on a shared tick enable. Periodic modes fold back to the programmed reload value after zero, and the other modes roll through the whole 16-bit or four-digit decimal range. Each counter has a terminal output that goes high after the tick that brings it to zero. Reload values and snapshots are moved one byte at a time. In the low-then-high access mode, separate read and write toggles track which byte comes next. The bus is a bidirectional 8-bit port with a chip select and read and write strobes, all sampled on the clock.

Top module: `prog_interval_timer`

## Requirements
- R1: A command byte at address 3 is decoded as channel = bits 7:6, access = bits 5:4, counting mode = bits 3:1, BCD = bit 0. Access 1, 2 or 3 stores the low six bits as the channel's setup, clears its reload value to zero, sets its update-pending flag and clears its latched, status-armed and both toggle flags.
- R2: Access 0 in a command byte for channels 0 to 2 copies that channel's current count into its snapshot only when no snapshot is already held. A second latch command before the snapshot is read is ignored, and the stored setup is unchanged.
- R3: Channel field 3 is read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. If bit 5 is 0, each selected channel takes a snapshot unless it already holds one. If bit 4 is 0, each selected channel is armed to return status on its next data read.
- R4: A data read on an armed channel returns status instead of the count: bits 5:0 are the setup, bit 6 is update-pending and bit 7 is the terminal output. The read disarms the channel, and the following read returns count bytes.
- R5: Every data write sets update-pending. Access 1 writes the reload low byte, access 2 writes the high byte, and access 3 writes low then high, tracked by a write toggle. After the last byte, the counter loads the reload value and update-pending clears.
- R6: Data reads return the low byte with access 1, the high byte with access 2, and low then high with access 3, tracked by a read toggle. A held snapshot is released after the last byte of the sequence.
- R7: A data read returns the snapshot while one is held, and the live count otherwise.
- R8: In counting modes 2, 3, 6 and 7, a tick at count zero reloads the reload value.
- R9: In counting modes 0, 1, 4 and 5, a tick at count zero wraps to 0xFFFF in binary or 0x9999 in BCD.
- R10: With BCD selected, each tick decrements the count as four decimal digits, with a borrow that ripples across digits (for example 0x0100 becomes 0x0099).
- R11: The terminal output of a channel goes high on the tick that leaves its count at zero, and falls on the next tick that leaves a nonzero count or on a load. Status bit 7 reports the same value.
- R12: A load that completes on the same cycle as a tick takes precedence over the decrement. A snapshot taken on a tick cycle captures the count from before that tick.
- R13: After reset every channel has setup 0x36 (low-then-high access, mode 3, binary), count 0, reload 0, all flags clear and its terminal output low. The bus is driven only while both chip select and read are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Shared count enable, one decrement per high cycle |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | 0 to 2 select a channel data port, 3 is the command port |
| data_io | inout | 8 | Bidirectional data bus |
| tc_out | output | 3 | Terminal output of each channel |

## Verification
A bus access and a counter tick can fall on the same clock. Two cases matter: a latch command during a tick, and the final byte of a reload write during a tick. The bench raises tick_en on the very cycle the command or the high byte is presented on the bus. A correct design snapshots the count from before the tick, and after the final byte it holds exactly the new reload value. A design that decrements first reads one lower, and one that drops the load keeps counting the old value, so both errors show up in the byte values read back afterwards.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_NCH   = 3;
    localparam int PIT_DW    = 8;
    localparam int PIT_CW    = 16;
    localparam int PIT_DIGITS = PIT_CW / 4;

    localparam logic [5:0] PIT_SETUP_RST = 6'h36;

    typedef struct packed {
        logic [5:0]        setup;
        logic [PIT_CW-1:0] reload;
        logic [PIT_CW-1:0] snap;
        logic              latched;
        logic              rtog;
        logic              wtog;
        logic              upd;
        logic              armed;
    } chan_t;

    function automatic logic [PIT_CW-1:0] bcd_dec(input logic [PIT_CW-1:0] v);
        logic [PIT_CW-1:0] r;
        logic              borrow;
        r      = v;
        borrow = 1'b1;
        for (int k = 0; k < PIT_DIGITS; k++) begin
            if (borrow) begin
                if (v[k*4 +: 4] == 4'd0) begin
                    r[k*4 +: 4] = 4'd9;
                end else begin
                    r[k*4 +: 4] = v[k*4 +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CW = PIT_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic [CW-1:0] reload,
    input  logic          periodic,
    input  logic          bcd,
    output logic [CW-1:0] cnt,
    output logic          tc
);

    localparam logic [CW-1:0] FULL_BIN = {CW{1'b1}};
    localparam logic [CW-1:0] FULL_BCD = {(CW/4){4'h9}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tc;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CW-1:0] step_val;

    always_comb begin
        if (ctr_q.cnt == '0) begin
            if (periodic)  step_val = reload;
            else if (bcd)  step_val = FULL_BCD;
            else           step_val = FULL_BIN;
        end else if (bcd) begin
            step_val = bcd_dec(ctr_q.cnt);
        end else begin
            step_val = ctr_q.cnt - 1'b1;
        end

        ctr_d = ctr_q;
        if (ld) begin
            ctr_d.cnt = ld_val;
            ctr_d.tc  = 1'b0;
        end else if (tick) begin
            ctr_d.cnt = step_val;
            ctr_d.tc  = (step_val == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign cnt = ctr_q.cnt;
    assign tc  = ctr_q.tc;

endmodule

// File: rtl/pit_rdsel.sv
module pit_rdsel
    import pit_pkg::*;
#(
    parameter int CW = PIT_CW,
    parameter int DW = PIT_DW
) (
    input  chan_t         ch,
    input  logic [CW-1:0] cnt,
    input  logic          tc,
    output logic [DW-1:0] rbyte
);

    logic [CW-1:0] src;

    always_comb begin
        src = ch.latched ? ch.snap : cnt;
        if (ch.armed) begin
            rbyte = {tc, ch.upd, ch.setup};
        end else begin
            unique case (ch.setup[5:4])
                2'd0:    rbyte = '0;
                2'd1:    rbyte = src[DW-1:0];
                2'd2:    rbyte = src[CW-1:DW];
                default: rbyte = ch.rtog ? src[CW-1:DW] : src[DW-1:0];
            endcase
        end
    end

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
    import pit_pkg::*;
#(
    parameter int NCH = PIT_NCH,
    parameter int DW  = PIT_DW,
    parameter int CW  = PIT_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    addr,
    inout  wire  [DW-1:0] data_io,
    output logic [NCH-1:0] tc_out
);

    localparam logic [1:0] CMD_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL   = 2'd3;

    typedef struct packed {
        chan_t [NCH-1:0] ch;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NCH-1:0]         ld_w;
    logic [NCH-1:0][CW-1:0] cnt_w;
    logic [NCH-1:0][CW-1:0] ldval_w;
    logic [NCH-1:0][CW-1:0] reload_w;
    logic [NCH-1:0][CW-1:0] snap_w;
    logic [NCH-1:0]         latched_w;
    logic [NCH-1:0]         armed_w;
    logic [NCH-1:0]         periodic_w;
    logic [NCH-1:0]         bcd_w;
    logic [NCH-1:0][DW-1:0] rbyte_w;

    logic          wr_cyc, rd_cyc;
    logic [DW-1:0] din, rdata;

    assign din    = data_io;
    assign wr_cyc = cs && wr;
    assign rd_cyc = cs && rd && !wr;

    always_comb begin
        regs_d = regs_q;
        ld_w   = '0;

        if (wr_cyc && addr == CMD_ADDR) begin
            if (din[7:6] == RB_SEL) begin
                for (int i = 0; i < NCH; i++) begin
                    if (din[i+1]) begin
                        if (!din[5] && !regs_q.ch[i].latched) begin
                            regs_d.ch[i].snap    = cnt_w[i];
                            regs_d.ch[i].latched = 1'b1;
                        end
                        if (!din[4]) regs_d.ch[i].armed = 1'b1;
                    end
                end
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (din[7:6] == 2'(i)) begin
                        if (din[5:4] == 2'd0) begin
                            if (!regs_q.ch[i].latched) begin
                                regs_d.ch[i].snap    = cnt_w[i];
                                regs_d.ch[i].latched = 1'b1;
                            end
                        end else begin
                            regs_d.ch[i].setup   = din[5:0];
                            regs_d.ch[i].reload  = '0;
                            regs_d.ch[i].upd     = 1'b1;
                            regs_d.ch[i].latched = 1'b0;
                            regs_d.ch[i].armed   = 1'b0;
                            regs_d.ch[i].rtog    = 1'b0;
                            regs_d.ch[i].wtog    = 1'b0;
                        end
                    end
                end
            end
        end else if (wr_cyc) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == 2'(i)) begin
                    regs_d.ch[i].upd = 1'b1;
                    unique case (regs_q.ch[i].setup[5:4])
                        2'd1: begin
                            regs_d.ch[i].reload[DW-1:0] = din;
                            ld_w[i] = 1'b1;
                        end
                        2'd2: begin
                            regs_d.ch[i].reload[CW-1:DW] = din;
                            ld_w[i] = 1'b1;
                        end
                        2'd3: begin
                            regs_d.ch[i].wtog = !regs_q.ch[i].wtog;
                            if (!regs_q.ch[i].wtog) begin
                                regs_d.ch[i].reload[DW-1:0] = din;
                            end else begin
                                regs_d.ch[i].reload[CW-1:DW] = din;
                                ld_w[i] = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                    if (ld_w[i]) regs_d.ch[i].upd = 1'b0;
                end
            end
        end else if (rd_cyc) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == 2'(i)) begin
                    if (regs_q.ch[i].armed) begin
                        regs_d.ch[i].armed = 1'b0;
                    end else begin
                        unique case (regs_q.ch[i].setup[5:4])
                            2'd1, 2'd2: regs_d.ch[i].latched = 1'b0;
                            2'd3: begin
                                regs_d.ch[i].rtog = !regs_q.ch[i].rtog;
                                if (regs_q.ch[i].rtog) regs_d.ch[i].latched = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                regs_q.ch[i]       <= '0;
                regs_q.ch[i].setup <= PIT_SETUP_RST;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign ldval_w[g]    = regs_d.ch[g].reload;
        assign reload_w[g]   = regs_q.ch[g].reload;
        assign snap_w[g]     = regs_q.ch[g].snap;
        assign latched_w[g]  = regs_q.ch[g].latched;
        assign armed_w[g]    = regs_q.ch[g].armed;
        assign periodic_w[g] = regs_q.ch[g].setup[2];
        assign bcd_w[g]      = regs_q.ch[g].setup[0];

        pit_counter #(.CW(CW)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_en),
            .ld       (ld_w[g]),
            .ld_val   (ldval_w[g]),
            .reload   (reload_w[g]),
            .periodic (periodic_w[g]),
            .bcd      (bcd_w[g]),
            .cnt      (cnt_w[g]),
            .tc       (tc_out[g])
        );

        pit_rdsel #(.CW(CW), .DW(DW)) u_rd (
            .ch    (regs_q.ch[g]),
            .cnt   (cnt_w[g]),
            .tc    (tc_out[g]),
            .rbyte (rbyte_w[g])
        );
    end

    always_comb begin
        rdata = '1;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = rbyte_w[i];
        end
    end

    assign data_io = rd_cyc ? rdata : 'z;

endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
#(
    parameter int NCH = PIT_NCH,
    parameter int CW  = PIT_CW
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick_en,
    input logic                   cs,
    input logic                   rd,
    input logic                   wr,
    input logic [NCH-1:0]         tc_out,
    input logic [NCH-1:0]         ld_w,
    input logic [NCH-1:0][CW-1:0] cnt_w,
    input logic [NCH-1:0][CW-1:0] ldval_w,
    input logic [NCH-1:0][CW-1:0] reload_w,
    input logic [NCH-1:0][CW-1:0] snap_w,
    input logic [NCH-1:0]         latched_w,
    input logic [NCH-1:0]         armed_w,
    input logic [NCH-1:0]         periodic_w,
    input logic [NCH-1:0]         bcd_w
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R11
        tc_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(tc_out[g]) |-> (cnt_w[g] == '0));

        // R8
        periodic_fold_chk: assert property (@(posedge clk) disable iff (rst)
            (tick_en && !ld_w[g] && cnt_w[g] == '0 && periodic_w[g])
            |=> (cnt_w[g] == $past(reload_w[g])));

        // R9
        full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (tick_en && !ld_w[g] && cnt_w[g] == '0 && !periodic_w[g] && !bcd_w[g])
            |=> (cnt_w[g] == {CW{1'b1}}));

        // R12
        load_wins_chk: assert property (@(posedge clk) disable iff (rst)
            ld_w[g] |=> (cnt_w[g] == $past(ldval_w[g])));

        // R2
        snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
            latched_w[g] |=> $stable(snap_w[g]));

        // R4
        disarm_on_access_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(armed_w[g]) |-> $past(cs && (rd || wr)));
    end

endmodule

bind prog_interval_timer pit_checker #(.NCH(NCH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .cs         (cs),
    .rd         (rd),
    .wr         (wr),
    .tc_out     (tc_out),
    .ld_w       (ld_w),
    .cnt_w      (cnt_w),
    .ldval_w    (ldval_w),
    .reload_w   (reload_w),
    .snap_w     (snap_w),
    .latched_w  (latched_w),
    .armed_w    (armed_w),
    .periodic_w (periodic_w),
    .bcd_w      (bcd_w)
);

// File: tb/sim_prog_interval_timer.sv
`timescale 1ns/1ps
module sim_prog_interval_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] tb_dout = 8'h00;
    logic       tb_drv = 1'b0;
    wire  [7:0] data_io;
    logic [2:0] tc_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    assign data_io = tb_drv ? tb_dout : 'z;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_interval_timer u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .data_io(data_io), .tc_out(tc_out)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr_port(input logic [1:0] a, input logic [7:0] d, input bit with_tick = 0);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; tb_dout = d; tb_drv = 1; tick_en = with_tick;
        @(negedge clk);
        cs = 0; wr = 0; tb_drv = 0; tick_en = 0;
    endtask

    task automatic rd_port(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1; rd = 1; addr = a;
        #1 d = data_io;
        @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic rd16(input logic [1:0] a, output int v);
        logic [7:0] lo, hi;
        rd_port(a, lo);
        rd_port(a, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1;
            repeat (n) @(negedge clk);
            tick_en = 0;
        end
    endtask

    task automatic prog16(input int ch, input int mode, input bit bcd, input int v);
        wr_port(2'd3, {ch[1:0], 2'b11, mode[2:0], bcd});
        wr_port(ch[1:0], v[7:0]);
        wr_port(ch[1:0], v[15:8]);
    endtask

    function automatic int bcd2bin(input int v);
        return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
    endfunction

    function automatic int bin2bcd(input int v);
        return (v % 10) | ((v / 10 % 10) << 4) | ((v / 100 % 10) << 8) | ((v / 1000 % 10) << 12);
    endfunction

    function automatic int expect_cnt(input int v, input int n, input int mode, input bit bcd);
        int vb, m, r;
        bit per;
        per = mode[1];
        vb  = bcd ? bcd2bin(v) : v;
        m   = per ? vb + 1 : (bcd ? 10000 : 65536);
        r   = ((vb - n) % m + m) % m;
        return bcd ? bin2bcd(r) : r;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int v;
        int modes[6] = '{0, 2, 3, 6, 1, 7};
        bit bcds[6]  = '{0, 0, 1, 0, 1, 1};

        repeat (3) @(negedge clk);
        rst = 0;

        // R13 reset state
        check("R13 tc_out", tc_out, 0);
        check("R13 bus idle", (data_io === 8'hzz), 1);
        wr_port(2'd3, 8'hE2);
        rd_port(2'd0, b);
        check("R13 status ch0", b, 8'h36);
        rd16(2'd0, v);
        check("R13 count ch0", v, 0);

        // R1 / R4 command decode and status
        wr_port(2'd3, 8'h74);
        wr_port(2'd3, 8'hE4);
        rd_port(2'd1, b);
        check("R1 R4 status after command", b, 8'h74);
        rd16(2'd1, v);
        check("R4 count after status read", v, 0);

        // R5 write sequencing and update-pending
        wr_port(2'd1, 8'h05);
        wr_port(2'd3, 8'hE4);
        rd_port(2'd1, b);
        check("R5 pending after low byte", b, 8'h74);
        wr_port(2'd1, 8'h00);
        wr_port(2'd3, 8'hE4);
        rd_port(2'd1, b);
        check("R5 pending cleared", b, 8'h34);
        rd16(2'd1, v);
        check("R7 live count", v, 5);

        // R8 R9 R10 sweep over channels and counting modes
        for (int ch = 0; ch < 3; ch++) begin
            for (int k = 0; k < 6; k++) begin
                int vv, vb;
                int ns[4];
                vv = bcds[k] ? 16'h0012 : (modes[k][1] ? 6 : 4);
                vb = bcds[k] ? 12 : vv;
                ns = '{0, 2, vb, vb + 3};
                for (int j = 0; j < 4; j++) begin
                    int got;
                    prog16(ch, modes[k], bcds[k], vv);
                    ticks(ns[j]);
                    wr_port(2'd3, {ch[1:0], 6'b000000});
                    rd16(ch[1:0], got);
                    check(bcds[k] ? "R10 bcd count" : (modes[k][1] ? "R8 periodic count" : "R9 full-range count"),
                          got, expect_cnt(vv, ns[j], modes[k], bcds[k]));
                end
            end
        end

        // R10 borrow across digits
        prog16(1, 0, 1, 16'h0100);
        ticks(1);
        wr_port(2'd3, 8'h40);
        rd16(2'd1, v);
        check("R10 digit borrow", v, 16'h0099);

        // R2 latch held, second latch ignored, setup unchanged
        prog16(0, 0, 0, 100);
        ticks(10);
        wr_port(2'd3, 8'h00);
        ticks(5);
        wr_port(2'd3, 8'h00);
        rd16(2'd0, v);
        check("R2 first snapshot kept", v, 90);
        rd16(2'd0, v);
        check("R7 live after release", v, 85);
        wr_port(2'd3, 8'hE2);
        rd_port(2'd0, b);
        check("R2 setup unchanged", b, 8'h30);

        // R5 R6 single-byte access modes
        wr_port(2'd3, 8'h94);
        wr_port(2'd2, 8'h07);
        ticks(2);
        wr_port(2'd3, 8'h80);
        ticks(1);
        rd_port(2'd2, b);
        check("R6 low-only snapshot", b, 8'h05);
        rd_port(2'd2, b);
        check("R6 snapshot released", b, 8'h04);
        wr_port(2'd3, 8'hA4);
        wr_port(2'd2, 8'h01);
        rd_port(2'd2, b);
        check("R5 high-only load", b, 8'h01);
        ticks(1);
        rd_port(2'd2, b);
        check("R6 high-only read", b, 8'h00);

        // R3 read-back across channels
        prog16(0, 2, 0, 50);
        prog16(1, 2, 0, 60);
        prog16(2, 2, 0, 70);
        ticks(4);
        wr_port(2'd3, 8'hDE);
        ticks(3);
        rd16(2'd0, v); check("R3 snapshot ch0", v, 46);
        rd16(2'd1, v); check("R3 snapshot ch1", v, 56);
        rd16(2'd2, v); check("R3 snapshot ch2", v, 66);
        ticks(2);
        wr_port(2'd3, 8'hCA);
        ticks(3);
        rd_port(2'd0, b); check("R3 status ch0", b, 8'h34);
        rd16(2'd0, v);    check("R3 count ch0", v, 41);
        rd16(2'd1, v);    check("R3 ch1 unselected live", v, 48);
        rd_port(2'd2, b); check("R3 status ch2", b, 8'h34);
        rd16(2'd2, v);    check("R3 count ch2", v, 61);

        // R11 terminal output
        prog16(2, 2, 0, 3);
        ticks(3);
        check("R11 tc high at zero", tc_out, 3'b100);
        wr_port(2'd3, 8'hE8);
        rd_port(2'd2, b);
        check("R11 status bit 7", b, 8'hB4);
        ticks(1);
        check("R11 tc low after reload", tc_out, 3'b000);

        // R12 bus access on a tick cycle
        prog16(0, 2, 0, 20);
        ticks(5);
        wr_port(2'd3, 8'h00, 1);
        rd16(2'd0, v);
        check("R12 snapshot before tick", v, 15);
        wr_port(2'd3, 8'h34);
        wr_port(2'd0, 8'h09);
        wr_port(2'd0, 8'h00, 1);
        wr_port(2'd3, 8'h00);
        rd16(2'd0, v);
        check("R12 load beats tick", v, 9);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule